// File: doc/BRIEF.md
# Pixel Format Packer

The packer takes one pixel with four 8-bit channels (alpha, red, green, blue) and turns it into one packed memory word of up to 32 bits. It also produces four byte-lane write strobes and a count of 2, 3 or 4 meaningful bytes. A single 4-bit format code selects both the bit depth and the channel order. The depths are 16-bit 4444, 16-bit 565, 24-bit 888 and 32-bit 8888. Two control bits choose whether the alpha channel is stored as given, stored inverted, or replaced by a constant pad. A 4-bit lane mask gates the strobes.

Pixels arrive over a valid/ready handshake and leave over a second one through a single output register. A pixel accepted in one cycle is presented on the output from the next cycle. A downstream stall holds the beat, and the input stays blocked until the beat is taken. Pixels carrying an unassigned format code are consumed and produce no beat.

Control word fields: format code in bits 11:8, alpha-invert in bit 12, lane mask in bits 19:16, alpha-store in bit 20. All other control bits are ignored. Packed data always sits in the low bytes of `out_data`. In every layout the first-named channel occupies the most significant bits.

Top module: `pxpk_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. A pixel accepted on a clock edge appears on the outputs right after that edge. While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_strb` and `out_nbytes` stay unchanged. Once the beat is taken with no new pixel, `out_valid` drops.
- R3: Format codes 0, 1, 2 and 3 pack the upper 4 bits of each channel. The layouts are {A,B,G,R}, {A,R,G,B}, {B,G,R,A} and {R,G,B,A} in `out_data[15:0]`, with bits 31:16 zero and `out_nbytes` = 2.
- R4: Code 6 packs {B[7:3],G[7:2],R[7:3]} and code 7 packs {R[7:3],G[7:2],B[7:3]} in `out_data[15:0]`. Bits 31:16 are zero and `out_nbytes` = 2.
- R5: Code 8 packs {B,G,R} and code 9 packs {R,G,B} in `out_data[23:0]`. Bits 31:24 are zero and `out_nbytes` = 3. Alpha is not used.
- R6: Codes 12, 13, 14 and 15 pack {A,B,G,R}, {A,R,G,B}, {B,G,R,A} and {R,G,B,A} in 32 bits, with `out_nbytes` = 4.
- R7: When alpha-store (bit 20) is 1, the alpha field holds the input alpha. It holds the input alpha inverted when alpha-invert (bit 12) is 1. For 4444 this value is reduced to its upper 4 bits.
- R8: When alpha-store is 0, every alpha field bit equals alpha-invert. Invert 1 gives an all-ones pad (0xFF for 8888, 0xF for 4444) and invert 0 gives zero.
- R9: `out_strb[i]` is 1 exactly when lane mask bit i (control bit 16+i) is 1 and i < `out_nbytes`.
- R10: Codes 4, 5, 10 and 11 consume the pixel (handshake as in R2) and emit no beat, so `out_valid` is 0 after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Packer can accept a pixel |
| in_ctrl | input | 32 | Control word: format, alpha and lane-mask fields |
| in_a | input | 8 | Alpha channel |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| out_valid | output | 1 | Packed beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 32 | Packed pixel, low-byte aligned |
| out_strb | output | 4 | Byte-lane write strobes |
| out_nbytes | output | 3 | Number of meaningful bytes (2, 3 or 4) |

## Verification
The bench uses the default build: 8-bit channels and four byte lanes, so the 4-bit format code has only 16 values. That makes it cheap to sweep every code against all four alpha store/invert combinations, several pixel values with distinct bit patterns in each channel, and full, alternating and empty-low lane masks. Every layout, every reduction, each pad value and each unassigned code is therefore compared with an arithmetic model. A separate stall sequence exercises holding a beat under backpressure and handing over between two beats in the same cycle.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
    localparam int CH_W     = 8;
    localparam int LANES    = 4;
    localparam int DATA_W   = CH_W * LANES;
    localparam int CTRL_W   = 32;
    localparam int CNT_W    = $clog2(LANES + 1);
    localparam int CODE_W   = 4;
    localparam int FMT_LSB  = 8;
    localparam int AINV_BIT = 12;
    localparam int LANE_LSB = 16;
    localparam int AEN_BIT  = 20;

    typedef enum logic [1:0] {
        DEPTH_4444 = 2'd0,
        DEPTH_565  = 2'd1,
        DEPTH_888  = 2'd2,
        DEPTH_8888 = 2'd3
    } depth_e;

    typedef struct packed {
        logic   legal;
        depth_e depth;
        logic   rgb_order;   // 1: red before blue
        logic   alpha_last;  // 1: alpha in the lowest field
    } fmt_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  strb;
        logic [CNT_W-1:0]  nbytes;
    } beat_t;

    function automatic fmt_t decode_fmt(input logic [CODE_W-1:0] code);
        fmt_t f;
        f.legal      = 1'b1;
        f.rgb_order  = code[0];
        f.alpha_last = code[1];
        case (code[3:2])
            2'b00: f.depth = DEPTH_4444;
            2'b01: begin
                f.depth = DEPTH_565;
                f.legal = code[1];
            end
            2'b10: begin
                f.depth = DEPTH_888;
                f.legal = !code[1];
            end
            default: f.depth = DEPTH_8888;
        endcase
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] depth_bytes(input fmt_t f);
        logic [CNT_W-1:0] n;
        if (!f.legal) begin
            n = '0;
        end else begin
            case (f.depth)
                DEPTH_888:  n = CNT_W'(3);
                DEPTH_8888: n = CNT_W'(4);
                default:    n = CNT_W'(2);
            endcase
        end
        return n;
    endfunction
endpackage

// File: rtl/pxpk_alpha_sel.sv
module pxpk_alpha_sel #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_in,
    input  logic         store_en,
    input  logic         invert,
    output logic [W-1:0] a_out
);
    always_comb begin
        if (store_en) begin
            a_out = a_in ^ {W{invert}};
        end else begin
            a_out = {W{invert}};
        end
    end
endmodule

// File: rtl/pxpk_reduce.sv
module pxpk_reduce #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 4
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] y
);
    localparam int DROP_W = IN_W - OUT_W;

    logic [DROP_W-1:0] unused_low;

    assign y          = x[IN_W-1 -: OUT_W];
    assign unused_low = x[DROP_W-1:0];
endmodule

// File: rtl/pxpk_lane_mask.sv
module pxpk_lane_mask #(
    parameter int LANES = 4,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] nbytes,
    input  logic [LANES-1:0] lane_en,
    output logic [LANES-1:0] strb
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb[i] = lane_en[i] && (nbytes > CNT_W'(i));
    end
endmodule

// File: rtl/pxpk_packer.sv
module pxpk_packer
    import pxpk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CTRL_W-1:0]    in_ctrl,
    input  logic [CH_W-1:0]      in_a,
    input  logic [CH_W-1:0]      in_r,
    input  logic [CH_W-1:0]      in_g,
    input  logic [CH_W-1:0]      in_b,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DATA_W-1:0]    out_data,
    output logic [LANES-1:0]     out_strb,
    output logic [CNT_W-1:0]     out_nbytes
);
    localparam int NIB_W = CH_W / 2;
    localparam int C5_W  = CH_W - 3;
    localparam int C6_W  = CH_W - 2;
    localparam int NCH   = 4;

    beat_t beat_d, beat_q;

    fmt_t             fmt;
    logic [CH_W-1:0]  alpha_w;
    logic [CH_W-1:0]  c_hi, c_lo;
    logic [CH_W-1:0]  chan [NCH];
    logic [NIB_W-1:0] nib  [NCH];
    logic [C5_W-1:0]  hi5, lo5;
    logic [C6_W-1:0]  g6;
    logic [CNT_W-1:0] nbytes_w;
    logic [LANES-1:0] strb_w;
    logic [DATA_W-1:0] word_w;
    logic              unused_ctrl;

    assign fmt         = decode_fmt(in_ctrl[FMT_LSB +: CODE_W]);
    assign nbytes_w    = depth_bytes(fmt);
    assign unused_ctrl = ^{in_ctrl[CTRL_W-1:AEN_BIT+1], in_ctrl[FMT_LSB-1:0]};

    assign c_hi = fmt.rgb_order ? in_r : in_b;
    assign c_lo = fmt.rgb_order ? in_b : in_r;

    pxpk_alpha_sel #(.W(CH_W)) u_alpha (
        .a_in     (in_a),
        .store_en (in_ctrl[AEN_BIT]),
        .invert   (in_ctrl[AINV_BIT]),
        .a_out    (alpha_w)
    );

    assign chan[0] = alpha_w;
    assign chan[1] = c_hi;
    assign chan[2] = in_g;
    assign chan[3] = c_lo;

    for (genvar i = 0; i < NCH; i++) begin : g_nib
        pxpk_reduce #(.IN_W(CH_W), .OUT_W(NIB_W)) u_nib (
            .x (chan[i]),
            .y (nib[i])
        );
    end

    pxpk_reduce #(.IN_W(CH_W), .OUT_W(C5_W)) u_hi5 (.x(c_hi), .y(hi5));
    pxpk_reduce #(.IN_W(CH_W), .OUT_W(C6_W)) u_g6  (.x(in_g), .y(g6));
    pxpk_reduce #(.IN_W(CH_W), .OUT_W(C5_W)) u_lo5 (.x(c_lo), .y(lo5));

    pxpk_lane_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
        .nbytes  (nbytes_w),
        .lane_en (in_ctrl[LANE_LSB +: LANES]),
        .strb    (strb_w)
    );

    always_comb begin
        word_w = '0;
        if (fmt.legal) begin
            case (fmt.depth)
                DEPTH_4444: word_w = fmt.alpha_last
                    ? DATA_W'({nib[1], nib[2], nib[3], nib[0]})
                    : DATA_W'({nib[0], nib[1], nib[2], nib[3]});
                DEPTH_565:  word_w = DATA_W'({hi5, g6, lo5});
                DEPTH_888:  word_w = DATA_W'({c_hi, in_g, c_lo});
                default:    word_w = fmt.alpha_last
                    ? {c_hi, in_g, c_lo, alpha_w}
                    : {alpha_w, c_hi, in_g, c_lo};
            endcase
        end
    end

    assign in_ready = !beat_q.valid || out_ready;

    always_comb begin
        beat_d = beat_q;
        if (beat_q.valid && out_ready) begin
            beat_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            beat_d.valid  = fmt.legal;
            beat_d.data   = word_w;
            beat_d.strb   = strb_w;
            beat_d.nbytes = nbytes_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign out_valid  = beat_q.valid;
    assign out_data   = beat_q.data;
    assign out_strb   = beat_q.strb;
    assign out_nbytes = beat_q.nbytes;
endmodule

// File: rtl/pxpk_packer_chk.sv
module pxpk_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [3:0]  fmt_code,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic [3:0]  out_strb,
    input logic [2:0]  out_nbytes
);
    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready)); // R2

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_strb) && $stable(out_nbytes))); // R2

    AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(fmt_code inside {4'd4, 4'd5, 4'd10, 4'd11}))
            |=> out_valid); // R2

    AST_UNUSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (fmt_code inside {4'd4, 4'd5, 4'd10, 4'd11}))
            |=> !out_valid); // R10

    AST_NBYTES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nbytes inside {3'd2, 3'd3, 4'd4})); // R9

    AST_STRB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_strb >> out_nbytes) == 4'd0)); // R9

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nbytes == 3'd2) |-> (out_data[31:16] == 16'd0)); // R3

    AST_UPPER_ZERO_24: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nbytes == 3'd3) |-> (out_data[31:24] == 8'd0)); // R5
endmodule

bind pxpk_packer pxpk_packer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .fmt_code   (in_ctrl[11:8]),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_strb   (out_strb),
    .out_nbytes (out_nbytes)
);

// File: tb/tb_pxpk_packer.sv
`timescale 1ns/1ps
module tb_pxpk_packer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_ctrl;
    logic [7:0]  in_a, in_r, in_g, in_b;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic [3:0]  out_strb;
    logic [2:0]  out_nbytes;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    pxpk_packer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctrl(in_ctrl), .in_a(in_a), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_strb(out_strb), .out_nbytes(out_nbytes)
    );

    // {valid, nbytes[2:0], strb[3:0], data[31:0]}
    function automatic logic [39:0] model(input logic [31:0] c, input logic [7:0] a,
                                          input logic [7:0] r, input logic [7:0] g,
                                          input logic [7:0] b);
        logic [3:0]  code = c[11:8];
        logic [7:0]  al;
        logic [31:0] d = 32'd0;
        int          nb = 0;
        logic [3:0]  st;
        if (c[20]) al = c[12] ? ~a : a;
        else       al = c[12] ? 8'hFF : 8'h00;
        case (code)
            4'd0:  begin d = {16'd0, al[7:4], b[7:4], g[7:4], r[7:4]}; nb = 2; end
            4'd1:  begin d = {16'd0, al[7:4], r[7:4], g[7:4], b[7:4]}; nb = 2; end
            4'd2:  begin d = {16'd0, b[7:4], g[7:4], r[7:4], al[7:4]}; nb = 2; end
            4'd3:  begin d = {16'd0, r[7:4], g[7:4], b[7:4], al[7:4]}; nb = 2; end
            4'd6:  begin d = {16'd0, b[7:3], g[7:2], r[7:3]}; nb = 2; end
            4'd7:  begin d = {16'd0, r[7:3], g[7:2], b[7:3]}; nb = 2; end
            4'd8:  begin d = {8'd0, b, g, r}; nb = 3; end
            4'd9:  begin d = {8'd0, r, g, b}; nb = 3; end
            4'd12: begin d = {al, b, g, r}; nb = 4; end
            4'd13: begin d = {al, r, g, b}; nb = 4; end
            4'd14: begin d = {b, g, r, al}; nb = 4; end
            4'd15: begin d = {r, g, b, al}; nb = 4; end
            default: nb = 0;
        endcase
        st = c[19:16] & 4'((1 << nb) - 1);
        return {(nb != 0), 3'(nb), st, d};
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] observed();
        return {out_valid, out_nbytes, out_strb, out_data};
    endfunction

    task automatic drive(input logic [31:0] c, input logic [7:0] a, input logic [7:0] r,
                         input logic [7:0] g, input logic [7:0] b);
        in_ctrl = c; in_a = a; in_r = r; in_g = g; in_b = b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [39:0] e1, e2;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        drive(32'd0, 8'd0, 8'd0, 8'd0, 8'd0);
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {39'd0, out_valid}, 40'd0);
        check("R1 reset in_ready", {39'd0, in_ready}, 40'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: every code, alpha mode, pixel and lane mask
        for (int f = 0; f < 16; f++) begin
            for (int am = 0; am < 4; am++) begin
                for (int p = 0; p < 4; p++) begin
                    for (int l = 0; l < 3; l++) begin
                        logic [31:0] c;
                        logic [7:0]  a, r, g, b;
                        logic [3:0]  ln;
                        string       tag;
                        ln = (l == 0) ? 4'hF : ((l == 1) ? 4'h5 : 4'hA);
                        a = 8'(p * 37 + 200); r = 8'(p * 91 + 17);
                        g = 8'(p * 53 + 129); b = 8'(p * 29 + 66);
                        c = {8'hA5, 3'b000, am[1], ln, 3'b000, am[0], 4'(f), 8'h5A};
                        if (f < 4)       tag = "R3";
                        else if (f == 6 || f == 7) tag = "R4";
                        else if (f == 8 || f == 9) tag = "R5";
                        else if (f >= 12) tag = "R6";
                        else             tag = "R10";
                        tag = {tag, am[1] ? " R7" : " R8", " R9"};
                        drive(c, a, r, g, b);
                        in_valid = 1'b1;
                        @(negedge clk);
                        in_valid = 1'b0;
                        e1 = model(c, a, r, g, b);
                        if (e1[39]) check(tag, observed(), e1);
                        else        check(tag, {39'd0, out_valid}, 40'd0);
                    end
                end
            end
        end

        // Backpressure and handover (R2)
        @(negedge clk);
        check("R2 idle after drain", {39'd0, out_valid}, 40'd0);
        out_ready = 1'b0;
        drive(32'h0011_0D00, 8'h80, 8'h12, 8'h34, 8'h56);
        e1 = model(32'h0011_0D00, 8'h80, 8'h12, 8'h34, 8'h56);
        in_valid = 1'b1;
        @(negedge clk);
        check("R2 first beat", observed(), e1);
        check("R2 in_ready low on stall", {39'd0, in_ready}, 40'd0);
        drive(32'h001F_0700, 8'h01, 8'hF8, 8'h0C, 8'h9F);
        e2 = model(32'h001F_0700, 8'h01, 8'hF8, 8'h0C, 8'h9F);
        @(negedge clk);
        check("R2 held under stall", observed(), e1);
        check("R2 still blocked", {39'd0, in_ready}, 40'd0);
        out_ready = 1'b1;
        #1;
        check("R2 in_ready follows out_ready", {39'd0, in_ready}, 40'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 handover to second beat", observed(), e2);
        @(negedge clk);
        check("R2 drained", {39'd0, out_valid}, 40'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule